// File: doc/BRIEF.md
# Packet PRBS Self-Test Generator and Checker

This block is a built-in self-test engine for a byte-wide data path. Its transmit half produces framed packets whose payload is a 15-bit pseudo-random sequence, with an idle gap between packets. The packet length, the gap length and the number of packets are set on input ports. A start command launches a run, and a busy output stays high until the last gap has ended. The transmit half can instead send one packet of constant data, either 64 or 1518 bytes long.

The receive half watches a byte stream marked by a valid strobe. In a normal setup this is the transmit stream after it has passed through some loopback path outside this block. The checker seeds its own LFSR from the first received bytes. It then predicts every following byte and counts the bytes that differ. It reports lock after a clean run of bytes. It reports loss of sync when errors cluster, and in that case it re-seeds from the incoming stream. The error counter either wraps or saturates, depending on a mode input.

Top module: `prbs_pkt_bist`

## Requirements
- R1: The payload follows x^15 + x^14 + 1. The state is seeded to all ones on start. Each step computes a new bit as state[14] xor state[13] and shifts it into state[0]. Eight steps make one byte, and the first new bit lands in bit 7 of the byte. The sequence carries on across packet boundaries and does not advance during gaps.
- R2: An accepted start sends pktCount packets (0 counts as 1), each pktLen bytes long (0 counts as 1). txValid is high on every packet byte. Each packet, the last one included, is followed by max(gapLen, 12) cycles with txValid low.
- R3: busy rises in the cycle after an accepted start and falls once the final gap ends, so it is high for packets × (length + gap) cycles. A start that arrives while busy is high is ignored.
- R4: With onePkt high at start, exactly one packet is sent. Every byte of it is 0xA5. Its length is 64 bytes when longPkt is low and 1518 bytes when longPkt is high. One gap follows the packet.
- R5: After start, and again after a loss of sync, the checker loads its state from the next two valid received bytes. It compares from the third byte onward, and bytes used for loading are never counted as errored.
- R6: locked rises after 32 consecutive error-free compared bytes. Only an accepted start or a loss of sync clears it.
- R7: errCount adds one for each compared byte that differs from the checker's prediction, and an accepted start clears it to 0.
- R8: When singleMode is low, errCount wraps from 255 to 0. When singleMode is high, it holds at 255.
- R9: Compared bytes are grouped into back-to-back windows of 64. The 8th errored byte within one window sets syncLost, clears locked and restarts acquisition. syncLost stays set until the next accepted start.
- R10: After reset, busy, txValid, locked, syncLost and errCount are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start command |
| singleMode | input | 1 | 1: error counter saturates, 0: wraps |
| onePkt | input | 1 | Send one constant-data packet |
| longPkt | input | 1 | Constant packet length: 1 = 1518, 0 = 64 |
| pktLen | input | 11 | PRBS packet length in bytes |
| gapLen | input | 8 | Gap in byte times (minimum 12 applied) |
| pktCount | input | 8 | Number of PRBS packets per run |
| txData | output | 8 | Generated byte |
| txValid | output | 1 | Generated byte valid |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | Received byte valid |
| busy | output | 1 | Generator run in progress |
| locked | output | 1 | Checker locked |
| syncLost | output | 1 | Checker lost sync (sticky) |
| errCount | output | 8 | Errored byte count |

## Verification
If the generator LFSR state is wrong, the very first payload byte shows it, and every later byte keeps showing it because the sequence never resets within a run. If the checker loaded its seed from the wrong bytes, every compared byte is flagged. errCount then climbs by one per byte starting from the third received byte, and the clustering rule raises syncLost within 8 bytes. Errors in the framing counters show up as a wrong total of busy cycles, payload bytes or idle cycles by the end of a run. Errors in the lock, window and saturation counters show up only at their thresholds: the 32nd clean byte, the 8th clustered error and the 255th error. For that reason the bench drives stimulus exactly up to those points and one byte past them.

// File: rtl/prbs_bist_pkg.sv
package prbs_bist_pkg;

  localparam int LFSR_W = 15;

  // Strobes from control to datapath
  typedef struct packed {
    logic genSeed;   // reload generator LFSR
    logic genStep;   // advance generator one byte
    logic sendConst; // emit constant byte
    logic chkClear;  // clear checker datapath state
    logic chkLoad;   // shift received byte into checker state
    logic chkCmp;    // compare received byte with prediction
  } bistStrb_t;

  // Eight steps of x^15 + x^14 + 1; new byte sits in bits [7:0]
  function automatic logic [LFSR_W-1:0] lfsrStep8(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int i = 0; i < 8; i++) t = {t[LFSR_W-2:0], t[14] ^ t[13]};
    return t;
  endfunction

endpackage

// File: rtl/prbs_bist_ctrl.sv
module prbs_bist_ctrl
  import prbs_bist_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int GAP_W     = 8,
  parameter int CNT_W     = 8,
  parameter int MIN_GAP   = 12,
  parameter int SHORT_LEN = 64,
  parameter int LONG_LEN  = 1518,
  parameter int LOCK_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int WIN_ERR   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             onePkt,
  input  logic             longPkt,
  input  logic [LEN_W-1:0] pktLen,
  input  logic [GAP_W-1:0] gapLen,
  input  logic [CNT_W-1:0] pktCount,
  input  logic             rxValid,
  input  logic             byteErr,
  output bistStrb_t        strb,
  output logic             txValid,
  output logic             busy,
  output logic             locked,
  output logic             syncLost
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int WE_W  = $clog2(WIN_ERR);

  typedef enum logic [1:0] {G_IDLE, G_PKT, G_GAP} genSt_t;

  genSt_t           genSt;
  logic [LEN_W-1:0] byteCnt, lenReg;
  logic [GAP_W-1:0] gapCnt, gapReg;
  logic [CNT_W-1:0] leftReg;
  logic             constReg;
  logic             startAcc;

  logic             acquiring, acqCnt;
  logic [RUN_W-1:0] goodRun;
  logic [WIN_W-1:0] winCnt;
  logic [WE_W-1:0]  winErr;

  assign startAcc = start && (genSt == G_IDLE);
  assign busy     = (genSt != G_IDLE);
  assign txValid  = (genSt == G_PKT);

  always_comb begin
    strb.genSeed   = startAcc;
    strb.genStep   = (genSt == G_PKT);
    strb.sendConst = constReg;
    strb.chkClear  = startAcc;
    strb.chkLoad   = !startAcc && rxValid && acquiring;
    strb.chkCmp    = !startAcc && rxValid && !acquiring;
  end

  // Generator framing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genSt    <= G_IDLE;
      byteCnt  <= '0;
      gapCnt   <= '0;
      lenReg   <= LEN_W'(1);
      gapReg   <= GAP_W'(MIN_GAP);
      leftReg  <= CNT_W'(1);
      constReg <= 1'b0;
    end else begin
      case (genSt)
        G_IDLE: if (start) begin
          genSt    <= G_PKT;
          byteCnt  <= '0;
          constReg <= onePkt;
          if (onePkt) lenReg <= longPkt ? LEN_W'(LONG_LEN) : LEN_W'(SHORT_LEN);
          else        lenReg <= (pktLen == '0) ? LEN_W'(1) : pktLen;
          gapReg   <= (gapLen < GAP_W'(MIN_GAP)) ? GAP_W'(MIN_GAP) : gapLen;
          leftReg  <= (onePkt || pktCount == '0) ? CNT_W'(1) : pktCount;
        end
        G_PKT: begin
          if (byteCnt == lenReg - LEN_W'(1)) begin
            genSt  <= G_GAP;
            gapCnt <= '0;
          end else byteCnt <= byteCnt + LEN_W'(1);
        end
        G_GAP: begin
          if (gapCnt == gapReg - GAP_W'(1)) begin
            if (leftReg == CNT_W'(1)) genSt <= G_IDLE;
            else begin
              leftReg <= leftReg - CNT_W'(1);
              byteCnt <= '0;
              genSt   <= G_PKT;
            end
          end else gapCnt <= gapCnt + GAP_W'(1);
        end
        default: genSt <= G_IDLE;
      endcase
    end
  end

  // Checker acquisition, lock and window supervision
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acquiring <= 1'b1;
      acqCnt    <= 1'b0;
      locked    <= 1'b0;
      syncLost  <= 1'b0;
      goodRun   <= '0;
      winCnt    <= '0;
      winErr    <= '0;
    end else if (startAcc) begin
      acquiring <= 1'b1;
      acqCnt    <= 1'b0;
      locked    <= 1'b0;
      syncLost  <= 1'b0;
      goodRun   <= '0;
      winCnt    <= '0;
      winErr    <= '0;
    end else if (strb.chkLoad) begin
      acqCnt <= ~acqCnt;
      if (acqCnt) acquiring <= 1'b0;
    end else if (strb.chkCmp) begin
      if (byteErr && winErr == WE_W'(WIN_ERR - 1)) begin
        syncLost  <= 1'b1;
        locked    <= 1'b0;
        acquiring <= 1'b1;
        acqCnt    <= 1'b0;
        goodRun   <= '0;
        winCnt    <= '0;
        winErr    <= '0;
      end else begin
        if (byteErr) goodRun <= '0;
        else if (goodRun != RUN_W'(LOCK_RUN)) goodRun <= goodRun + RUN_W'(1);
        if (!byteErr && goodRun == RUN_W'(LOCK_RUN - 1)) locked <= 1'b1;
        if (winCnt == WIN_W'(WIN_LEN - 1)) begin
          winCnt <= '0;
          winErr <= '0;
        end else begin
          winCnt <= winCnt + WIN_W'(1);
          winErr <= winErr + WE_W'(byteErr);
        end
      end
    end
  end

  AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> busy); // R2
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy); // R3
  AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (syncLost && !start) |=> syncLost); // R9
  AST_LOCK_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncLost) |-> !locked); // R6

endmodule

// File: rtl/prbs_bist_dp.sv
module prbs_bist_dp
  import prbs_bist_pkg::*;
#(
  parameter int          ERR_W      = 8,
  parameter logic [7:0]  CONST_BYTE = 8'hA5
) (
  input  logic             clk,
  input  logic             rstN,
  input  bistStrb_t        strb,
  input  logic             singleMode,
  input  logic [7:0]       rxData,
  output logic [7:0]       txData,
  output logic             byteErr,
  output logic [ERR_W-1:0] errCount
);
  localparam logic [LFSR_W-1:0] SEED    = '1;
  localparam logic [ERR_W-1:0]  ERR_MAX = '1;

  logic [LFSR_W-1:0] genState, genNext, chkState, chkNext;

  assign genNext = lfsrStep8(genState);
  assign chkNext = lfsrStep8(chkState);
  assign txData  = strb.sendConst ? CONST_BYTE : genNext[7:0];
  assign byteErr = strb.chkCmp && (chkNext[7:0] != rxData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) genState <= SEED;
    else if (strb.genSeed) genState <= SEED;
    else if (strb.genStep) genState <= genNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkState <= SEED;
    else if (strb.chkLoad) chkState <= {chkState[6:0], rxData};
    else if (strb.chkCmp) chkState <= chkNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errCount <= '0;
    else if (strb.chkClear) errCount <= '0;
    else if (byteErr && !(singleMode && errCount == ERR_MAX))
      errCount <= errCount + ERR_W'(1);
  end

  AST_ERR_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (singleMode && errCount == ERR_MAX && !strb.chkClear) |=> errCount == ERR_MAX); // R8
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.chkClear |=> (errCount == $past(errCount) ||
                        errCount == $past(errCount) + ERR_W'(1))); // R7
  AST_NO_LOAD_ERR: assert property (@(posedge clk) disable iff (!rstN)
    strb.chkLoad |-> !byteErr); // R5

endmodule

// File: rtl/prbs_pkt_bist.sv
module prbs_pkt_bist
  import prbs_bist_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int GAP_W     = 8,
  parameter int CNT_W     = 8,
  parameter int ERR_W     = 8,
  parameter int MIN_GAP   = 12,
  parameter int SHORT_LEN = 64,
  parameter int LONG_LEN  = 1518,
  parameter int LOCK_RUN  = 32,
  parameter int WIN_LEN   = 64,
  parameter int WIN_ERR   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             singleMode,
  input  logic             onePkt,
  input  logic             longPkt,
  input  logic [LEN_W-1:0] pktLen,
  input  logic [GAP_W-1:0] gapLen,
  input  logic [CNT_W-1:0] pktCount,
  output logic [7:0]       txData,
  output logic             txValid,
  input  logic [7:0]       rxData,
  input  logic             rxValid,
  output logic             busy,
  output logic             locked,
  output logic             syncLost,
  output logic [ERR_W-1:0] errCount
);
  bistStrb_t strb;
  logic      byteErr;

  prbs_bist_ctrl #(
    .LEN_W(LEN_W), .GAP_W(GAP_W), .CNT_W(CNT_W), .MIN_GAP(MIN_GAP),
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .LOCK_RUN(LOCK_RUN),
    .WIN_LEN(WIN_LEN), .WIN_ERR(WIN_ERR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .onePkt(onePkt), .longPkt(longPkt),
    .pktLen(pktLen), .gapLen(gapLen), .pktCount(pktCount), .rxValid(rxValid),
    .byteErr(byteErr), .strb(strb), .txValid(txValid), .busy(busy),
    .locked(locked), .syncLost(syncLost)
  );

  prbs_bist_dp #(.ERR_W(ERR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .singleMode(singleMode),
    .rxData(rxData), .txData(txData), .byteErr(byteErr), .errCount(errCount)
  );

endmodule

// File: tb/tb_prbs_pkt_bist.sv
module tb_prbs_pkt_bist;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, singleMode = 1'b0, onePkt = 1'b0, longPkt = 1'b0;
  logic [10:0] pktLen = 11'd1;
  logic [7:0]  gapLen = 8'd12, pktCount = 8'd1;
  logic [7:0]  txData, rxData, errCount;
  logic        txValid, busy, locked, syncLost;
  logic [7:0]  rxFlip = 8'h00;

  int checks = 0, fails = 0;
  int corrMode = 0;
  int byteIdx = 0, busyCyc = 0, validCyc = 0, idleBusy = 0, mism = 0;
  logic [14:0] model = 15'h7FFF;

  always #4 clk = ~clk;

  assign rxData = txData ^ rxFlip;

  prbs_pkt_bist dut (
    .clk(clk), .rstN(rstN), .start(start), .singleMode(singleMode),
    .onePkt(onePkt), .longPkt(longPkt), .pktLen(pktLen), .gapLen(gapLen),
    .pktCount(pktCount), .txData(txData), .txValid(txValid), .rxData(rxData),
    .rxValid(txValid), .busy(busy), .locked(locked), .syncLost(syncLost),
    .errCount(errCount)
  );

  function automatic logic [14:0] step8(input logic [14:0] s);
    logic [14:0] t;
    t = s;
    for (int i = 0; i < 8; i++) t = {t[13:0], t[14] ^ t[13]};
    return t;
  endfunction

  function automatic bit corruptAt(input int k, input int mode);
    case (mode)
      1: return (k >= 2) && ((k - 2) % 10 == 9);
      2: return (k >= 50) && (k <= 57);
      3: return (k == 2);
      default: return 1'b0;
    endcase
  endfunction

  // Monitor: samples at the falling edge, sets corruption for the current byte
  always @(negedge clk) begin
    if (start && !busy) begin
      byteIdx = 0; busyCyc = 0; validCyc = 0; idleBusy = 0; mism = 0;
      model = 15'h7FFF;
      rxFlip = 8'h00;
    end else begin
      if (busy) busyCyc++;
      if (busy && !txValid) idleBusy++;
      rxFlip = 8'h00;
      if (txValid) begin
        logic [7:0] expB;
        if (onePkt) expB = 8'hA5;
        else begin
          model = step8(model);
          expB = model[7:0];
        end
        if (txData !== expB) mism++;
        if (corruptAt(byteIdx, corrMode)) rxFlip = 8'h01;
        validCyc++;
        byteIdx++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runTest(input int len, input int gap, input int cnt, input bit one,
                         input bit lng, input bit sat, input int mode, input bit midStart);
    @(posedge clk); #1;
    pktLen = 11'(len); gapLen = 8'(gap); pktCount = 8'(cnt);
    onePkt = one; longPkt = lng; singleMode = sat; corrMode = mode;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (midStart) begin
      repeat (10) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic frameChecks(input int n, input int l, input int g, input string tag);
    chk(busyCyc == n * (l + g), {tag, " R3 busy cycles"}, busyCyc, n * (l + g));
    chk(validCyc == n * l, {tag, " R2 payload bytes"}, validCyc, n * l);
    chk(idleBusy == n * g, {tag, " R2 gap cycles"}, idleBusy, n * g);
    chk(mism == 0, {tag, " R1 payload data"}, mism, 0);
  endtask

  initial begin
    int l, g, n, ge, ec;
    bit sm;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !txValid, "R10 busy/txValid after reset", int'({busy, txValid}), 0);
    chk(!locked && !syncLost && errCount == 0, "R10 status after reset",
        int'({locked, syncLost, errCount}), 0);

    // Random framing runs with a clean loopback
    for (int r = 0; r < 6; r++) begin
      l = $urandom_range(80, 1); g = $urandom_range(30, 0); n = $urandom_range(4, 1);
      sm = 1'($urandom_range(1, 0));
      ge = (g < 12) ? 12 : g;
      runTest(l, g, n, 1'b0, 1'b0, sm, 0, 1'b0);
      frameChecks(n, l, ge, "random");
      chk(errCount == 0, "R7 clean run has no errors", errCount, 0);
      chk(!syncLost, "R9 clean run keeps sync", syncLost, 0);
    end

    // Gap clamp and zero length
    runTest(5, 3, 2, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    frameChecks(2, 5, 12, "gap clamp");
    runTest(0, 12, 0, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    frameChecks(1, 1, 12, "zero len");

    // R3 start while busy is ignored
    runTest(30, 15, 2, 1'b0, 1'b0, 1'b0, 0, 1'b1);
    frameChecks(2, 30, 15, "mid start");

    // R4 constant packets
    runTest(7, 12, 5, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    frameChecks(1, 64, 12, "R4 const 64");
    runTest(7, 20, 5, 1'b1, 1'b1, 1'b0, 0, 1'b0);
    frameChecks(1, 1518, 20, "R4 const 1518");

    // R6 lock threshold: 33 bytes -> 31 compared, 34 bytes -> 32 compared
    runTest(33, 12, 1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    chk(!locked, "R6 no lock after 31 clean compares", locked, 0);
    runTest(34, 12, 1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    chk(locked, "R6 lock after 32 clean compares", locked, 1);

    // R1 R5 sequence continues across one-byte packets
    runTest(1, 12, 40, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    chk(locked && errCount == 0, "R1 R5 stream continuous across packets",
        int'({locked, errCount}), 256);

    // R5 first compared byte is the third one
    runTest(40, 12, 1, 1'b0, 1'b0, 1'b0, 3, 1'b0);
    chk(errCount == 1, "R5 third byte compared", errCount, 1);

    // R8 wrap and saturate: 399 errored bytes, at most 7 per window
    runTest(1000, 12, 4, 1'b0, 1'b0, 1'b0, 1, 1'b0);
    ec = 399 % 256;
    chk(errCount == ec, "R8 continuous mode wraps", errCount, ec);
    chk(!syncLost, "R9 sparse errors keep sync", syncLost, 0);
    runTest(1000, 12, 4, 1'b0, 1'b0, 1'b1, 1, 1'b0);
    chk(errCount == 255, "R8 single mode saturates", errCount, 255);

    // R9 eight errors in one window, then reacquire and relock
    runTest(100, 12, 1, 1'b0, 1'b0, 1'b0, 2, 1'b0);
    chk(syncLost, "R9 sync lost after 8 errors in window", syncLost, 1);
    chk(errCount == 8, "R9 R7 errors counted up to loss", errCount, 8);
    chk(locked, "R6 R9 relock after reacquire", locked, 1);

    // R7 start clears counter, R9 start clears syncLost
    runTest(10, 12, 1, 1'b0, 1'b0, 1'b0, 0, 1'b0);
    chk(errCount == 0, "R7 start clears errCount", errCount, 0);
    chk(!syncLost, "R9 start clears syncLost", syncLost, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule